// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit address pointers for an 8-bit microcontroller core and decides which of them each pointer operation acts on. The core hands it decoded one-cycle strobes (load immediate, step, indexed jump, code-memory read, external read, external write), a strobe saying that the selection-inverting prefix opcode (0xA5) was accepted, and writes to a small auxiliary control register. The block returns the chosen pointer as a combinational address, the control register readback and the readback of both pointers.

A select bit in the control register names the active pointer. A prefix flips that choice for exactly one following pointer operation, except the indexed jump, which always follows the select bit but still consumes the prefix. Each pointer has its own direction bit. The bit turns a step into a decrement and also sets the direction of the optional automatic update that follows a memory access. Constant-zero bits directly above the select bit let software toggle the selection by writing back the register value plus one.

Top module: `dual_ptr_unit`

## Requirements
- R1: After reset both pointers read 0x0000, the control register reads 0x00 and no prefix is pending.
- R2: The target pointer is pointer 1 when (select bit XOR pending prefix) is 1, else pointer 0. The select bit is control bit 0. During a read or write access, addrOut shows the target pointer.
- R3: A load writes immData into the target pointer only. The other pointer keeps its value.
- R4: A step on a pointer whose direction bit is 0 adds one modulo 2^16, so 0xFFFF becomes 0x0000.
- R5: A step on a pointer whose direction bit is 1 subtracts one modulo 2^16, so 0x0000 becomes 0xFFFF. Pointer 0's direction bit is control bit 4 and pointer 1's is control bit 5.
- R6: A code read, external read or external write moves the target pointer by one in its direction only when autoUpd is 1. During that access, addrOut presents the value from before the update. With autoUpd at 0 both pointers are unchanged.
- R7: Control bits 1 and 2 always read 0 and ignore writes. All other control bits read back as written, so writing the readback plus one toggles only the select bit.
- R8: An accepted prefix inverts the selection for the next load, step or access only. It is then cleared.
- R9: An indexed jump presents the pointer named by the select bit alone, even with a prefix pending. It changes neither pointer and clears the pending prefix.
- R10: Each pointer's direction bit affects only that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prefixHit | input | 1 | Selection-inverting prefix accepted this cycle |
| opLoad | input | 1 | Load immediate into target pointer |
| opInc | input | 1 | Step target pointer |
| opJump | input | 1 | Indexed jump through pointer |
| opCodeRd | input | 1 | Code-memory read through pointer |
| opExtRd | input | 1 | External read through pointer |
| opExtWr | input | 1 | External write through pointer |
| autoUpd | input | 1 | Post-access update enable for the access strobes |
| immData | input | 16 | Immediate value for a load |
| ctrlWrEn | input | 1 | Write strobe for the control register |
| ctrlWrData | input | 8 | Control register write value |
| ctrlRdData | output | 8 | Control register readback |
| addrOut | output | 16 | Address from the pointer chosen for the current operation |
| ptr0Rd | output | 16 | Pointer 0 readback |
| ptr1Rd | output | 16 | Pointer 1 readback |

## Verification
The bench builds the block with its default parameters: 16-bit pointers, an 8-bit control register, the select bit at 0, constant zeros up to bit 2 and direction bits at 4 and 5. With these values a single load can place a pointer at 0xFFFF or 0x0000, so both wrap boundaries are reached in one step each. Writing the control readback plus one shows the carry being absorbed by the constant-zero bits. Directed scenarios combine prefix, select bit and per-pointer direction to show the prefix consumed by exactly one operation, including a jump.

// File: rtl/dual_ptr_pkg.sv
package dual_ptr_pkg;
  // command from control to the pointer datapath
  typedef struct packed {
    logic tgt;   // 1: pointer 1, 0: pointer 0
    logic ld;    // load immediate
    logic step;  // move by one
    logic down;  // direction of the move
  } ptr_cmd_t;
endpackage

// File: rtl/dual_ptr_ctrl.sv
module dual_ptr_ctrl
  import dual_ptr_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int SEL_POS  = 0,
  parameter int ZERO_HI  = 2,
  parameter int DIR0_POS = 4,
  parameter int DIR1_POS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prefixHit,
  input  logic              opLoad,
  input  logic              opInc,
  input  logic              opJump,
  input  logic              opCodeRd,
  input  logic              opExtRd,
  input  logic              opExtWr,
  input  logic              autoUpd,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  output logic              prefixActive,
  output ptr_cmd_t          cmd
);
  // constant-zero field between the select bit and ZERO_HI
  localparam logic [CTRL_W-1:0] ZERO_MASK =
    CTRL_W'((1 << (ZERO_HI + 1)) - (1 << (SEL_POS + 1)));

  logic [CTRL_W-1:0] ctrlQ;
  logic              prefixQ;
  logic              anyOp;
  logic              accessOp;
  logic              selBit;
  logic              tgtSel;

  assign accessOp = opCodeRd | opExtRd | opExtWr;
  assign anyOp    = opLoad | opInc | opJump | accessOp;
  assign selBit   = ctrlQ[SEL_POS];
  // the jump never honours the prefix
  assign tgtSel   = opJump ? selBit : (selBit ^ prefixQ);

  always_comb begin
    cmd.tgt  = tgtSel;
    cmd.ld   = opLoad;
    cmd.step = opInc | (accessOp & autoUpd);
    cmd.down = tgtSel ? ctrlQ[DIR1_POS] : ctrlQ[DIR0_POS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWrEn) begin
      ctrlQ <= ctrlWrData & ~ZERO_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prefixQ <= 1'b0;
    end else if (prefixHit) begin
      prefixQ <= 1'b1;
    end else if (anyOp) begin
      prefixQ <= 1'b0;
    end
  end

  assign ctrlRdData   = ctrlQ;
  assign prefixActive = prefixQ;
endmodule

// File: rtl/dual_ptr_regs.sv
module dual_ptr_regs
  import dual_ptr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptr_cmd_t         cmd,
  input  logic [PTR_W-1:0] immData,
  output logic [PTR_W-1:0] addrOut,
  output logic [PTR_W-1:0] ptr0Rd,
  output logic [PTR_W-1:0] ptr1Rd
);
  localparam int NUM_PTR = 2;

  logic [NUM_PTR-1:0][PTR_W-1:0] ptrVal;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    localparam logic IDX = 1'(g);
    logic [PTR_W-1:0] ptrQ;
    logic             hit;

    assign hit = (cmd.tgt == IDX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ <= '0;
      end else if (hit && cmd.ld) begin
        ptrQ <= immData;
      end else if (hit && cmd.step) begin
        ptrQ <= cmd.down ? (ptrQ - 1'b1) : (ptrQ + 1'b1);
      end
    end

    assign ptrVal[g] = ptrQ;
  end

  assign addrOut = ptrVal[cmd.tgt];
  assign ptr0Rd  = ptrVal[0];
  assign ptr1Rd  = ptrVal[1];
endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
  import dual_ptr_pkg::*;
#(
  parameter int PTR_W    = 16,
  parameter int CTRL_W   = 8,
  parameter int SEL_POS  = 0,
  parameter int ZERO_HI  = 2,
  parameter int DIR0_POS = 4,
  parameter int DIR1_POS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prefixHit,
  input  logic              opLoad,
  input  logic              opInc,
  input  logic              opJump,
  input  logic              opCodeRd,
  input  logic              opExtRd,
  input  logic              opExtWr,
  input  logic              autoUpd,
  input  logic [PTR_W-1:0]  immData,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  output logic [PTR_W-1:0]  addrOut,
  output logic [PTR_W-1:0]  ptr0Rd,
  output logic [PTR_W-1:0]  ptr1Rd
);
  ptr_cmd_t cmd;
  logic     prefixActive;

  dual_ptr_ctrl #(
    .CTRL_W(CTRL_W), .SEL_POS(SEL_POS), .ZERO_HI(ZERO_HI),
    .DIR0_POS(DIR0_POS), .DIR1_POS(DIR1_POS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .prefixHit(prefixHit),
    .opLoad(opLoad), .opInc(opInc), .opJump(opJump),
    .opCodeRd(opCodeRd), .opExtRd(opExtRd), .opExtWr(opExtWr),
    .autoUpd(autoUpd), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .prefixActive(prefixActive), .cmd(cmd)
  );

  dual_ptr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .immData(immData),
    .addrOut(addrOut), .ptr0Rd(ptr0Rd), .ptr1Rd(ptr1Rd)
  );
endmodule

// File: rtl/dual_ptr_unit_chk.sv
module dual_ptr_unit_chk #(
  parameter int PTR_W   = 16,
  parameter int CTRL_W  = 8,
  parameter int SEL_POS = 0,
  parameter int ZERO_HI = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              prefixHit,
  input logic              prefixActive,
  input logic              opLoad,
  input logic              opInc,
  input logic              opJump,
  input logic              opCodeRd,
  input logic              opExtRd,
  input logic              opExtWr,
  input logic              autoUpd,
  input logic [PTR_W-1:0]  immData,
  input logic              ctrlWrEn,
  input logic [CTRL_W-1:0] ctrlWrData,
  input logic [CTRL_W-1:0] ctrlRdData,
  input logic [PTR_W-1:0]  addrOut,
  input logic [PTR_W-1:0]  ptr0Rd,
  input logic [PTR_W-1:0]  ptr1Rd
);
  logic effSel;
  logic accessOp;
  assign effSel   = ctrlRdData[SEL_POS] ^ prefixActive;
  assign accessOp = opCodeRd | opExtRd | opExtWr;

  // R3
  load_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opLoad && !effSel) |=> (ptr0Rd == $past(immData)) && $stable(ptr1Rd));

  // R3
  load_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opLoad && effSel) |=> (ptr1Rd == $past(immData)) && $stable(ptr0Rd));

  // R2
  addr_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessOp && effSel) |-> (addrOut == ptr1Rd));

  // R9
  jump_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opJump && !opLoad && !opInc && !accessOp) |=> $stable(ptr0Rd) && $stable(ptr1Rd));

  // R8
  prefix_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((opLoad || opInc || opJump || accessOp) && !prefixHit) |=> !prefixActive);

  // R6
  no_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessOp && !autoUpd && !opLoad && !opInc) |=> $stable(ptr0Rd) && $stable(ptr1Rd));

  // R7
  zero_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> (ctrlRdData[ZERO_HI:SEL_POS+1] == '0)
                 && (ctrlRdData[SEL_POS] == $past(ctrlWrData[SEL_POS])));
endmodule

bind dual_ptr_unit dual_ptr_unit_chk #(
  .PTR_W(PTR_W), .CTRL_W(CTRL_W), .SEL_POS(SEL_POS), .ZERO_HI(ZERO_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .prefixHit(prefixHit), .prefixActive(prefixActive),
  .opLoad(opLoad), .opInc(opInc), .opJump(opJump), .opCodeRd(opCodeRd),
  .opExtRd(opExtRd), .opExtWr(opExtWr), .autoUpd(autoUpd), .immData(immData),
  .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
  .addrOut(addrOut), .ptr0Rd(ptr0Rd), .ptr1Rd(ptr1Rd)
);

// File: tb/test_dual_ptr_unit.sv
module test_dual_ptr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int K_LOAD = 0, K_INC = 1, K_JUMP = 2, K_CODE = 3,
                 K_XRD = 4, K_XWR = 5, K_PRE = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        prefixHit = 1'b0;
  logic        opLoad = 1'b0, opInc = 1'b0, opJump = 1'b0;
  logic        opCodeRd = 1'b0, opExtRd = 1'b0, opExtWr = 1'b0;
  logic        autoUpd = 1'b0;
  logic [15:0] immData = '0;
  logic        ctrlWrEn = 1'b0;
  logic [7:0]  ctrlWrData = '0;
  logic [7:0]  ctrlRdData;
  logic [15:0] addrOut, ptr0Rd, ptr1Rd;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_ptr_unit i_dual_ptr_unit (
    .clk(clk), .rstN(rstN), .prefixHit(prefixHit),
    .opLoad(opLoad), .opInc(opInc), .opJump(opJump),
    .opCodeRd(opCodeRd), .opExtRd(opExtRd), .opExtWr(opExtWr),
    .autoUpd(autoUpd), .immData(immData), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .addrOut(addrOut), .ptr0Rd(ptr0Rd), .ptr1Rd(ptr1Rd)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one strobe for one clock edge; seen = addrOut while the strobe is up
  task automatic issue(input int kind, input logic upd, input logic [15:0] imm,
                       output logic [15:0] seen);
    @(negedge clk);
    autoUpd = upd;
    immData = imm;
    case (kind)
      K_LOAD:  opLoad = 1'b1;
      K_INC:   opInc = 1'b1;
      K_JUMP:  opJump = 1'b1;
      K_CODE:  opCodeRd = 1'b1;
      K_XRD:   opExtRd = 1'b1;
      K_XWR:   opExtWr = 1'b1;
      default: prefixHit = 1'b1;
    endcase
    #1 seen = addrOut;
    @(posedge clk);
    #1;
    {opLoad, opInc, opJump, opCodeRd, opExtRd, opExtWr, prefixHit, autoUpd} = '0;
  endtask

  task automatic writeCtrl(input logic [7:0] val);
    @(negedge clk);
    ctrlWrEn = 1'b1;
    ctrlWrData = val;
    @(posedge clk);
    #1 ctrlWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 ptr0", ptr0Rd, 16'h0000);
    check("R1 ptr1", ptr1Rd, 16'h0000);
    check("R1 ctrl", {8'h00, ctrlRdData}, 16'h0000);
  endtask

  task automatic testSelect();
    logic [15:0] s;
    issue(K_LOAD, 0, 16'h1234, s);
    writeCtrl(8'h01);
    issue(K_LOAD, 0, 16'hABCD, s);
    check("R3 ptr0 kept", ptr0Rd, 16'h1234);
    check("R3 ptr1 loaded", ptr1Rd, 16'hABCD);
    issue(K_XRD, 0, 16'h0, s);
    check("R2 sel1 addr", s, 16'hABCD);
    writeCtrl(8'h00);
    issue(K_XRD, 0, 16'h0, s);
    check("R2 sel0 addr", s, 16'h1234);
    check("R6 no update ptr0", ptr0Rd, 16'h1234);
    check("R6 no update ptr1", ptr1Rd, 16'hABCD);
  endtask

  task automatic testIncrement();
    logic [15:0] s;
    issue(K_LOAD, 0, 16'hFFFE, s);
    issue(K_INC, 0, 16'h0, s);
    check("R4 inc", ptr0Rd, 16'hFFFF);
    issue(K_INC, 0, 16'h0, s);
    check("R4 wrap", ptr0Rd, 16'h0000);
    check("R4 other kept", ptr1Rd, 16'hABCD);
  endtask

  task automatic testDirection();
    logic [15:0] s;
    writeCtrl(8'h10);
    issue(K_LOAD, 0, 16'h0000, s);
    issue(K_INC, 0, 16'h0, s);
    check("R5 dec wrap", ptr0Rd, 16'hFFFF);
    issue(K_PRE, 0, 16'h0, s);
    issue(K_LOAD, 0, 16'h0005, s);
    check("R8 prefix load ptr1", ptr1Rd, 16'h0005);
    check("R3 prefix load keeps ptr0", ptr0Rd, 16'hFFFF);
    issue(K_PRE, 0, 16'h0, s);
    issue(K_INC, 0, 16'h0, s);
    check("R10 ptr1 counts up", ptr1Rd, 16'h0006);
    check("R10 ptr0 untouched", ptr0Rd, 16'hFFFF);
    issue(K_INC, 0, 16'h0, s);
    check("R8 prefix consumed", ptr0Rd, 16'hFFFE);
    check("R8 ptr1 kept", ptr1Rd, 16'h0006);
  endtask

  task automatic testAutoUpdate();
    logic [15:0] s;
    writeCtrl(8'h20);
    issue(K_LOAD, 0, 16'h0100, s);
    issue(K_PRE, 0, 16'h0, s);
    issue(K_LOAD, 0, 16'h0200, s);
    issue(K_CODE, 1, 16'h0, s);
    check("R6 code pre-update addr", s, 16'h0100);
    check("R6 code post-inc", ptr0Rd, 16'h0101);
    issue(K_PRE, 0, 16'h0, s);
    issue(K_XWR, 1, 16'h0, s);
    check("R6 write pre-update addr", s, 16'h0200);
    check("R6 write post-dec", ptr1Rd, 16'h01FF);
    issue(K_XRD, 1, 16'h0, s);
    check("R6 read pre-update addr", s, 16'h0101);
    check("R6 read post-inc", ptr0Rd, 16'h0102);
    issue(K_XRD, 0, 16'h0, s);
    check("R6 no qualifier", ptr0Rd, 16'h0102);
  endtask

  task automatic testJump();
    logic [15:0] s;
    writeCtrl(8'h01);
    issue(K_PRE, 0, 16'h0, s);
    issue(K_JUMP, 0, 16'h0, s);
    check("R9 jump ignores prefix", s, 16'h01FF);
    check("R9 ptr0 kept", ptr0Rd, 16'h0102);
    check("R9 ptr1 kept", ptr1Rd, 16'h01FF);
    issue(K_XRD, 0, 16'h0, s);
    check("R9 prefix consumed by jump", s, 16'h01FF);
  endtask

  task automatic testCtrlReg();
    writeCtrl(8'hFF);
    check("R7 zero field", {8'h00, ctrlRdData}, 16'h00F9);
    writeCtrl(8'h30);
    writeCtrl(ctrlRdData + 8'h01);
    check("R7 toggle to 1", {8'h00, ctrlRdData}, 16'h0031);
    writeCtrl(ctrlRdData + 8'h01);
    check("R7 toggle to 0", {8'h00, ctrlRdData}, 16'h0030);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSelect();
    testIncrement();
    testDirection();
    testAutoUpdate();
    testJump();
    testCtrlReg();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule